// File: doc/BRIEF.md
# Memory-Type Cache Allocation Policy

This unit decides, one access per cycle, whether a cache line is allocated, whether a store goes out to memory, and how each line's coherence state moves. The decision depends on a 3-bit memory-type code that comes with each access. The unit keeps, for a small direct-mapped set of lines, the coherence state (Invalid, Shared, Exclusive, Modified) and a record of any fill that is still outstanding. Matching addresses to memory types, holding the line data and timing the bus are the work of the neighbouring blocks.

An access gives a read/write flag, a line index and a type code. The unit answers in the same cycle with allocate, memory-write, cached-data-update, combinable, speculation-allowed, ownership-upgrade and illegal-type outputs, and it shows the current state of the addressed line. A fill response names a line and reports the data as shared, exclusive or dirty. An ownership grant names a line. State changes from accesses, fills and grants take effect on the next clock edge.

Top module: `mtp_policy`

## Requirements
- R1: Type codes are 0 uncacheable, 1 write-combining, 4 writethrough, 5 write-protect and 6 writeback. Codes 2, 3 and 7 are handled as uncacheable, and `dec_illegal` is high only in the cycle of such an access.
- R2: An uncacheable access never allocates, is never combinable, has `dec_spec_ok` low, asserts `dec_mem_write` for writes, and leaves the line state unchanged.
- R3: A write-combining access never allocates and has `dec_combine` high. A read has `dec_spec_ok` high and a write has it low. A write asserts `dec_mem_write`.
- R4: A writethrough or write-protect read that misses (the line is Invalid and no fill is outstanding) asserts `dec_alloc`. The fill that answers it leaves the line Shared whatever the fill kind.
- R5: A writethrough write always asserts `dec_mem_write`. On a hit it also asserts `dec_line_write`. On a miss it does not allocate and leaves the state unchanged.
- R6: A write-protect write asserts `dec_mem_write`, keeps `dec_line_write` and `dec_illegal` low, and leaves the state unchanged.
- R7: A writeback read miss asserts `dec_alloc`. The answering fill sets the line from `fill_kind`: 0 gives Shared, 1 gives Exclusive, 2 gives Modified and 3 gives Shared.
- R8: A writeback write miss asserts `dec_alloc`. An answering fill of kind 1 or 2 leaves the line Modified, and kind 0 or 3 leaves it Shared.
- R9: A writeback write hit on an Exclusive or Modified line asserts `dec_line_write`, keeps `dec_mem_write` low, and the line is Modified from the next cycle.
- R10: A writeback write hit on a Shared line asserts `dec_upgrade_req` and the line stays Shared. A grant on a Shared line makes it Modified, and a grant on any other line is ignored.
- R11: A miss on a line whose fill is still outstanding requests no new allocation. A fill for a line with nothing outstanding is ignored.
- R12: `hit_state` shows the state of line `acc_idx` (0 Invalid, 1 Shared, 2 Exclusive, 3 Modified). Updates land on the next edge. A synchronous reset makes every line Invalid with nothing outstanding.
- R13: `dec_spec_ok` is high for reads of every type except uncacheable, and low for every write.
- R14: When a fill or grant hits the same line as an access in the same cycle, the access is decided on the state from before the edge. The fill or grant result and any change from the access are both applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_idx | input | IDX_W | Line index of the access |
| acc_mtype | input | 3 | Memory-type code |
| fill_valid | input | 1 | Fill response present |
| fill_idx | input | IDX_W | Line being filled |
| fill_kind | input | 2 | 0 shared, 1 exclusive, 2 dirty, 3 shared |
| grant_valid | input | 1 | Ownership grant present |
| grant_idx | input | IDX_W | Line being granted |
| dec_alloc | output | 1 | Allocate and request a fill |
| dec_mem_write | output | 1 | Write goes to memory |
| dec_line_write | output | 1 | Cached data is updated |
| dec_combine | output | 1 | Access may be combined |
| dec_spec_ok | output | 1 | Access may be speculative |
| dec_illegal | output | 1 | Reserved type code seen |
| dec_upgrade_req | output | 1 | Ownership upgrade needed |
| hit_state | output | 2 | State of line acc_idx |

## Verification
The collision that matters is a fill or a grant landing on the same line as an access in the same cycle. Then the access's decision and the fill or grant result are both settled at one edge. The bench provokes this in directed steps: a repeated miss together with its fill, and a Shared write hit together with its grant. Random traffic over only eight lines, with frequent fills and grants, keeps producing such coincidences. A behavioural model, fed the same inputs, predicts every output every cycle. A later access to the line shows through `hit_state` whether the right final state was stored.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_st_e;

    typedef enum logic [2:0] {
        MC_UC,
        MC_WC,
        MC_WT,
        MC_WP,
        MC_WB
    } mem_cls_e;

    typedef enum logic [1:0] {
        PD_NONE,
        PD_SHR,
        PD_RD,
        PD_OWN
    } pend_e;

    typedef enum logic [1:0] {
        FK_SHARED = 2'd0,
        FK_EXCL   = 2'd1,
        FK_DIRTY  = 2'd2,
        FK_RSVD   = 2'd3
    } fill_kind_e;

    typedef struct packed {
        line_st_e st;
        pend_e    pd;
    } line_rec_t;

    // Final line state once a fill answers an outstanding miss
    function automatic line_st_e fill_result(pend_e pd, fill_kind_e kind);
        line_st_e r;
        r = LS_SHR;
        case (pd)
            PD_RD: begin
                case (kind)
                    FK_EXCL:  r = LS_EXC;
                    FK_DIRTY: r = LS_MOD;
                    default:  r = LS_SHR;
                endcase
            end
            PD_OWN: begin
                if (kind == FK_EXCL || kind == FK_DIRTY) r = LS_MOD;
                else                                     r = LS_SHR;
            end
            default: r = LS_SHR;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mtp_type_decode.sv
module mtp_type_decode
    import mtp_pkg::*;
(
    input  logic [2:0] code,
    output mem_cls_e   cls,
    output logic       illegal
);
    always_comb begin
        illegal = 1'b0;
        case (code)
            3'd0:    cls = MC_UC;
            3'd1:    cls = MC_WC;
            3'd4:    cls = MC_WT;
            3'd5:    cls = MC_WP;
            3'd6:    cls = MC_WB;
            default: begin
                cls     = MC_UC;
                illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/mtp_line_table.sv
module mtp_line_table
    import mtp_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output line_rec_t        rd_rec,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [1:0]       fill_kind,
    input  logic             grant_valid,
    input  logic [IDX_W-1:0] grant_idx,
    input  logic             upd_st_en,
    input  line_st_e         upd_st,
    input  logic             upd_pd_en,
    input  pend_e            upd_pd,
    input  logic [IDX_W-1:0] upd_idx
);
    localparam int NUM_LINES = 1 << IDX_W;

    typedef struct packed {
        line_rec_t [NUM_LINES-1:0] lines;
    } tab_t;

    tab_t tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (fill_valid && tab_q.lines[fill_idx].pd != PD_NONE) begin
            tab_d.lines[fill_idx].st = fill_result(tab_q.lines[fill_idx].pd,
                                                   fill_kind_e'(fill_kind));
            tab_d.lines[fill_idx].pd = PD_NONE;
        end
        if (grant_valid && tab_q.lines[grant_idx].st == LS_SHR) begin
            tab_d.lines[grant_idx].st = LS_MOD;
        end
        if (upd_st_en) begin
            tab_d.lines[upd_idx].st = upd_st;
        end
        if (upd_pd_en) begin
            tab_d.lines[upd_idx].pd = upd_pd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tab_q <= '0;
        else     tab_q <= tab_d;
    end

    assign rd_rec = tab_q.lines[rd_idx];
endmodule

// File: rtl/mtp_access_decide.sv
module mtp_access_decide
    import mtp_pkg::*;
(
    input  logic      acc_valid,
    input  logic      acc_write,
    input  mem_cls_e  cls,
    input  logic      illegal,
    input  line_rec_t rec,
    output logic      alloc,
    output logic      mem_write,
    output logic      line_write,
    output logic      combine,
    output logic      spec_ok,
    output logic      illegal_o,
    output logic      upgrade_req,
    output logic      upd_st_en,
    output line_st_e  upd_st,
    output logic      upd_pd_en,
    output pend_e     upd_pd
);
    logic miss, merged;

    assign miss   = (rec.st == LS_INV);
    assign merged = miss && (rec.pd != PD_NONE);

    always_comb begin
        alloc       = 1'b0;
        mem_write   = 1'b0;
        line_write  = 1'b0;
        combine     = 1'b0;
        spec_ok     = 1'b0;
        illegal_o   = 1'b0;
        upgrade_req = 1'b0;
        upd_st_en   = 1'b0;
        upd_st      = LS_MOD;
        upd_pd_en   = 1'b0;
        upd_pd      = PD_NONE;
        if (acc_valid) begin
            illegal_o = illegal;
            combine   = (cls == MC_WC);
            spec_ok   = !acc_write && (cls != MC_UC);
            case (cls)
                MC_WT, MC_WP: begin
                    if (!acc_write) begin
                        if (miss && !merged) begin
                            alloc     = 1'b1;
                            upd_pd_en = 1'b1;
                            upd_pd    = PD_SHR;
                        end
                    end else begin
                        mem_write  = 1'b1;
                        line_write = (cls == MC_WT) && !miss;
                    end
                end
                MC_WB: begin
                    if (miss) begin
                        if (!merged) begin
                            alloc     = 1'b1;
                            upd_pd_en = 1'b1;
                            upd_pd    = acc_write ? PD_OWN : PD_RD;
                        end
                    end else if (acc_write) begin
                        if (rec.st == LS_SHR) begin
                            upgrade_req = 1'b1;
                        end else begin
                            line_write = 1'b1;
                            upd_st_en  = 1'b1;
                            upd_st     = LS_MOD;
                        end
                    end
                end
                default: mem_write = acc_write;
            endcase
        end
    end
endmodule

// File: rtl/mtp_policy.sv
module mtp_policy
    import mtp_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [2:0]       acc_mtype,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [1:0]       fill_kind,
    input  logic             grant_valid,
    input  logic [IDX_W-1:0] grant_idx,
    output logic             dec_alloc,
    output logic             dec_mem_write,
    output logic             dec_line_write,
    output logic             dec_combine,
    output logic             dec_spec_ok,
    output logic             dec_illegal,
    output logic             dec_upgrade_req,
    output logic [1:0]       hit_state
);
    mem_cls_e  cls;
    logic      illegal;
    line_rec_t rec;
    logic      upd_st_en, upd_pd_en;
    line_st_e  upd_st;
    pend_e     upd_pd;

    mtp_type_decode u_dec (
        .code    (acc_mtype),
        .cls     (cls),
        .illegal (illegal)
    );

    mtp_line_table #(.IDX_W(IDX_W)) u_table (
        .clk         (clk),
        .rst         (rst),
        .rd_idx      (acc_idx),
        .rd_rec      (rec),
        .fill_valid  (fill_valid),
        .fill_idx    (fill_idx),
        .fill_kind   (fill_kind),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .upd_st_en   (upd_st_en),
        .upd_st      (upd_st),
        .upd_pd_en   (upd_pd_en),
        .upd_pd      (upd_pd),
        .upd_idx     (acc_idx)
    );

    mtp_access_decide u_decide (
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .cls         (cls),
        .illegal     (illegal),
        .rec         (rec),
        .alloc       (dec_alloc),
        .mem_write   (dec_mem_write),
        .line_write  (dec_line_write),
        .combine     (dec_combine),
        .spec_ok     (dec_spec_ok),
        .illegal_o   (dec_illegal),
        .upgrade_req (dec_upgrade_req),
        .upd_st_en   (upd_st_en),
        .upd_st      (upd_st),
        .upd_pd_en   (upd_pd_en),
        .upd_pd      (upd_pd)
    );

    assign hit_state = rec.st;
endmodule

// File: rtl/mtp_policy_chk.sv
module mtp_policy_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic             acc_write,
    input logic [IDX_W-1:0] acc_idx,
    input logic [2:0]       acc_mtype,
    input logic             dec_alloc,
    input logic             dec_mem_write,
    input logic             dec_combine,
    input logic             dec_spec_ok,
    input logic             dec_illegal,
    input logic             dec_upgrade_req,
    input logic [1:0]       hit_state
);
    // R1
    illegal_as_uc_chk: assert property (@(posedge clk) disable iff (rst)
        dec_illegal |-> (acc_valid && !dec_alloc && !dec_combine && !dec_spec_ok));

    // R2
    uc_no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_mtype == 3'd0) |-> (!dec_alloc && !dec_combine && !dec_spec_ok));

    // R3
    wc_combine_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_mtype == 3'd1) |-> (dec_combine && !dec_alloc && dec_spec_ok == !acc_write));

    // R5
    wt_store_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && (acc_mtype == 3'd4 || acc_mtype == 3'd5)) |-> dec_mem_write);

    // R9
    wb_hit_mod_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_mtype == 3'd6 && (hit_state == 2'd2 || hit_state == 2'd3))
        |=> (acc_idx != $past(acc_idx) || hit_state == 2'd3));

    // R10
    upgrade_shared_chk: assert property (@(posedge clk) disable iff (rst)
        dec_upgrade_req |-> (hit_state == 2'd1 && acc_write && acc_mtype == 3'd6));

    // R13
    store_no_spec_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write) |-> !dec_spec_ok);

    // R12
    reset_invalid_chk: assert property (@(posedge clk)
        rst |=> (hit_state == 2'd0));
endmodule

bind mtp_policy mtp_policy_chk #(.IDX_W(IDX_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .acc_valid       (acc_valid),
    .acc_write       (acc_write),
    .acc_idx         (acc_idx),
    .acc_mtype       (acc_mtype),
    .dec_alloc       (dec_alloc),
    .dec_mem_write   (dec_mem_write),
    .dec_combine     (dec_combine),
    .dec_spec_ok     (dec_spec_ok),
    .dec_illegal     (dec_illegal),
    .dec_upgrade_req (dec_upgrade_req),
    .hit_state       (hit_state)
);

// File: tb/mtp_policy_test.sv
module mtp_policy_test;
    localparam int IW = 3;
    localparam int NL = 1 << IW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_valid = 1'b0, acc_write = 1'b0;
    logic [IW-1:0] acc_idx = '0;
    logic [2:0]    acc_mtype = 3'd0;
    logic          fill_valid = 1'b0;
    logic [IW-1:0] fill_idx = '0;
    logic [1:0]    fill_kind = 2'd0;
    logic          grant_valid = 1'b0;
    logic [IW-1:0] grant_idx = '0;
    logic          dec_alloc, dec_mem_write, dec_line_write, dec_combine;
    logic          dec_spec_ok, dec_illegal, dec_upgrade_req;
    logic [1:0]    hit_state;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // model: state 0 I,1 S,2 E,3 M; outstanding 0 none,1 shared-only,2 wb read,3 wb write
    int mst[NL];
    int mpd[NL];

    always #10 clk = ~clk;

    mtp_policy #(.IDX_W(IW)) uut (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_idx(acc_idx), .acc_mtype(acc_mtype),
        .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_kind(fill_kind),
        .grant_valid(grant_valid), .grant_idx(grant_idx),
        .dec_alloc(dec_alloc), .dec_mem_write(dec_mem_write), .dec_line_write(dec_line_write),
        .dec_combine(dec_combine), .dec_spec_ok(dec_spec_ok), .dec_illegal(dec_illegal),
        .dec_upgrade_req(dec_upgrade_req), .hit_state(hit_state)
    );

    function automatic int fill_to_state(int pd, int kind);
        if (pd == 2) return (kind == 1) ? 2 : (kind == 2) ? 3 : 1;
        if (pd == 3) return (kind == 1 || kind == 2) ? 3 : 1;
        return 1;
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // drive one cycle, compare all outputs against the model, advance the model
    task automatic tick(input bit av, input bit aw, input int ai, input int mt,
                        input bit fv, input int fi, input int fk,
                        input bit gv, input int gi, input string forced);
        int nst[NL];
        int npd[NL];
        int e_al, e_mw, e_lw, e_cb, e_sp, e_il, e_up, e_hs;
        bit ill, miss, pend;
        string tag;
        @(negedge clk);
        acc_valid = av; acc_write = aw; acc_idx = IW'(ai); acc_mtype = 3'(mt);
        fill_valid = fv; fill_idx = IW'(fi); fill_kind = 2'(fk);
        grant_valid = gv; grant_idx = IW'(gi);
        #5;
        foreach (nst[k]) begin nst[k] = mst[k]; npd[k] = mpd[k]; end
        e_al = 0; e_mw = 0; e_lw = 0; e_cb = 0; e_sp = 0; e_il = 0; e_up = 0;
        e_hs = mst[ai];
        ill  = !(mt == 0 || mt == 1 || mt == 4 || mt == 5 || mt == 6);
        miss = (mst[ai] == 0);
        pend = (mpd[ai] != 0);
        if (ill)                       tag = "R1";
        else if (mt == 0)              tag = "R2";
        else if (mt == 1)              tag = "R3";
        else if (!aw && mt != 6)       tag = "R4";
        else if (mt == 4)              tag = "R5";
        else if (mt == 5)              tag = "R6";
        else if (!aw)                  tag = "R7";
        else if (miss)                 tag = "R8";
        else if (mst[ai] == 1)         tag = "R10";
        else                           tag = "R9";
        if (!av) tag = "R12";
        if (forced != "") tag = forced;
        if (av) begin
            e_il = ill;
            e_cb = (mt == 1);
            e_sp = (!aw && mt != 0 && !ill);
            if (mt == 4 || mt == 5) begin
                if (!aw) begin
                    if (miss && !pend) begin e_al = 1; npd[ai] = 1; end
                end else begin
                    e_mw = 1;
                    e_lw = (mt == 4 && !miss);
                end
            end else if (mt == 6) begin
                if (miss) begin
                    if (!pend) begin e_al = 1; npd[ai] = aw ? 3 : 2; end
                end else if (aw) begin
                    if (mst[ai] == 1) e_up = 1;
                    else begin e_lw = 1; nst[ai] = 3; end
                end
            end else begin
                e_mw = aw;
            end
        end
        if (fv && mpd[fi] != 0) begin
            nst[fi] = fill_to_state(mpd[fi], fk);
            npd[fi] = 0;
        end
        if (gv && mst[gi] == 1) nst[gi] = 3;
        cmp(tag,   "alloc",      dec_alloc,       e_al);
        cmp(tag,   "mem_write",  dec_mem_write,   e_mw);
        cmp(tag,   "line_write", dec_line_write,  e_lw);
        cmp(tag,   "combine",    dec_combine,     e_cb);
        cmp("R13", "spec_ok",    dec_spec_ok,     e_sp);
        cmp(tag,   "illegal",    dec_illegal,     e_il);
        cmp(tag,   "upgrade",    dec_upgrade_req, e_up);
        cmp("R12", "hit_state",  hit_state,       e_hs);
        foreach (nst[k]) begin mst[k] = nst[k]; mpd[k] = npd[k]; end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        foreach (mst[k]) begin mst[k] = 0; mpd[k] = 0; end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12: every line Invalid after reset
        for (int i = 0; i < NL; i++) tick(0, 0, i, 0, 0, 0, 0, 0, 0, "R12");

        // R7 then R9: wb read miss, exclusive fill, write hit to Modified
        tick(1, 0, 1, 6, 0, 0, 0, 0, 0, "R7");
        tick(0, 0, 1, 0, 1, 1, 1, 0, 0, "R7");
        tick(1, 0, 1, 6, 0, 0, 0, 0, 0, "R7");
        tick(1, 1, 1, 6, 0, 0, 0, 0, 0, "R9");
        tick(0, 0, 1, 0, 0, 0, 0, 0, 0, "R9");
        // R7 dirty fill gives Modified
        tick(1, 0, 7, 6, 0, 0, 0, 0, 0, "R7");
        tick(0, 0, 7, 0, 1, 7, 2, 0, 0, "R7");
        // R10 and R14: shared line, write requests upgrade, grant with write same cycle
        tick(1, 0, 2, 6, 0, 0, 0, 0, 0, "R7");
        tick(0, 0, 2, 0, 1, 2, 0, 0, 0, "R7");
        tick(1, 1, 2, 6, 0, 0, 0, 0, 0, "R10");
        tick(0, 0, 2, 0, 0, 0, 0, 1, 6, "R10");
        tick(1, 1, 2, 6, 0, 0, 0, 1, 2, "R14");
        tick(0, 0, 2, 0, 0, 0, 0, 0, 0, "R14");
        // R8: wb write miss, exclusive fill -> Modified; shared fill -> Shared
        tick(1, 1, 3, 6, 0, 0, 0, 0, 0, "R8");
        tick(0, 0, 3, 0, 1, 3, 1, 0, 0, "R8");
        tick(1, 1, 0, 6, 0, 0, 0, 0, 0, "R8");
        tick(0, 0, 0, 0, 1, 0, 3, 0, 0, "R8");
        // R4: writethrough read miss, dirty fill still Shared; R5 write hit
        tick(1, 0, 4, 4, 0, 0, 0, 0, 0, "R4");
        tick(0, 0, 4, 0, 1, 4, 2, 0, 0, "R4");
        tick(1, 1, 4, 4, 0, 0, 0, 0, 0, "R5");
        tick(1, 1, 4, 5, 0, 0, 0, 0, 0, "R6");
        tick(1, 1, 5, 4, 0, 0, 0, 0, 0, "R5");
        tick(0, 0, 5, 0, 0, 0, 0, 0, 0, "R5");
        // R11 and R14: merged miss, stray fill ignored, fill with miss same cycle
        tick(1, 0, 5, 6, 0, 0, 0, 0, 0, "R11");
        tick(1, 0, 5, 6, 0, 0, 0, 0, 0, "R11");
        tick(0, 0, 6, 0, 1, 6, 2, 0, 0, "R11");
        tick(0, 0, 6, 0, 0, 0, 0, 0, 0, "R11");
        tick(1, 1, 5, 6, 1, 5, 1, 0, 0, "R14");
        tick(0, 0, 5, 0, 0, 0, 0, 0, 0, "R14");
        // R1, R2, R3: reserved codes, uncacheable, write-combining
        tick(1, 0, 1, 2, 0, 0, 0, 0, 0, "R1");
        tick(1, 1, 1, 3, 0, 0, 0, 0, 0, "R1");
        tick(1, 0, 6, 7, 0, 0, 0, 0, 0, "R1");
        tick(1, 0, 6, 0, 0, 0, 0, 0, 0, "R1");
        tick(1, 1, 1, 0, 0, 0, 0, 0, 0, "R2");
        tick(1, 0, 6, 0, 0, 0, 0, 0, 0, "R2");
        tick(1, 0, 6, 1, 0, 0, 0, 0, 0, "R3");
        tick(1, 1, 6, 1, 0, 0, 0, 0, 0, "R3");

        // random traffic over all types, fills and grants
        for (int n = 0; n < 4000; n++) begin
            int r;
            int mt;
            r  = $urandom_range(0, 9);
            mt = (r < 3) ? 6 : (r < 5) ? 4 : (r < 6) ? 5 : $urandom_range(0, 7);
            tick($urandom_range(0, 9) < 7, $urandom_range(0, 1) == 1,
                 $urandom_range(0, NL - 1), mt,
                 $urandom_range(0, 9) < 3, $urandom_range(0, NL - 1), $urandom_range(0, 3),
                 $urandom_range(0, 9) < 2, $urandom_range(0, NL - 1), "");
        end

        @(negedge clk);
        acc_valid = 1'b0; fill_valid = 1'b0; grant_valid = 1'b0;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule